// File: doc/BRIEF.md
# Half-Rate Transmit Serializer with Bit Slip

This block turns a stream of parallel words into a serial bit stream for one transmit lane. The word width W is a build-time parameter of 8 or 10 bits. The serial line runs at twice the rate of the fast clock, so every fast-clock cycle the block presents a pair of serial bits. A word is accepted once every W/2 fast-clock cycles, and its bits leave least significant first.

Before serialization each word can be rearranged in three ways, all set by static controls. The first is a per-byte bit flip applied at the input. The second is a reversal of the whole word. The third is a bit-slip delay of 0 to W-1 bit periods. To build the slipped word, the block keeps the previous rearranged word as history and takes a W-bit window out of the previous and current words.

A small controller sequences the work. It has two states. In ST_IDLE no word is held and the output is zero. On a valid strobe the transition ST_IDLE -> ST_SHIFT loads a word. ST_SHIFT emits one pair per cycle. At the last pair of a word, a strobe causes ST_SHIFT -> ST_SHIFT, which reloads the next word. If no strobe arrives at that point, the transition ST_SHIFT -> ST_IDLE is taken.

Top module: `tx_slip_serializer`

## Requirements
- R1: Words are accepted only at a word boundary: in ST_IDLE, or in the last of the W/2 pair cycles of ST_SHIFT. With a strobe at every boundary, words follow each other with no gap.
- R2: Serial bits of each word leave least significant bit first. In `out_pair`, bit 0 is the earlier serial bit and bit 1 is the later one.
- R3: The first pair of a word accepted at clock edge k appears right after edge k. `out_valid` is high for the W/2 consecutive cycles that carry that word.
- R4: With `flip_en` high, bits are reversed inside each 8-bit group counted from bit 0. A partial top group (bits 9:8 when W=10) is reversed within itself. For W=8, an input of 8'hBC becomes 8'h3D.
- R5: With `rev_en` high, word bit n takes bit W-1-n of its input.
- R6: When both options are on, the byte flip is applied first and the whole-word reversal second.
- R7: A slip of s delays the serial stream by s bit periods. The s bits sent first after reset are zero.
- R8: `slip_amt` is sampled only when a word is accepted, and it applies from that word on. The stream history is kept across the change. A value above W-1 acts as W-1.
- R9: A strobe in ST_SHIFT away from the last pair cycle is ignored, together with its word.
- R10: If no strobe arrives at the last pair cycle, the block returns to ST_IDLE with `out_valid` low and `out_pair` zero.
- R11: A synchronous active-high reset clears the state, the shift register and the slip history. While reset is applied, the outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (half-rate serial) clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe, honoured at word boundaries |
| in_word | input | W | Parallel word |
| flip_en | input | 1 | Per-byte bit flip enable |
| rev_en | input | 1 | Whole-word bit reversal enable |
| slip_amt | input | $clog2(W) | Bit-slip delay in bit periods |
| out_pair | output | 2 | Two serial bits; bit 0 is the earlier one |
| out_valid | output | 1 | High while a word is being shifted out |

## Verification
The bench builds the block twice, once with W=8 and once with W=10. For each build it sweeps every combination of flip, reversal and slip value (0 to W-1). Both widths are needed to reach the full-byte flip case and the partial-group flip case, and the W=10 build also reaches slip clamping through a 4-bit slip port. Each run also includes a stray mid-word strobe, a slip change in the middle of the stream, and a trailing gap with no strobe.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } txs_state_e;
endpackage

// File: rtl/txs_bitorder.sv
module txs_bitorder #(
    parameter int W = 10
) (
    input  logic [W-1:0] d_in,
    input  logic         flip_en,
    input  logic         rev_en,
    output logic [W-1:0] d_out
);
    localparam int GRP = 8;

    logic [W-1:0] flipped;
    logic [W-1:0] mid;
    logic [W-1:0] reversed;

    // per-group flip; a short top group mirrors inside its own span
    for (genvar b = 0; b < W; b++) begin : g_flip
        localparam int BASE = (b / GRP) * GRP;
        localparam int SPAN = ((W - BASE) < GRP) ? (W - BASE) : GRP;
        assign flipped[b] = d_in[BASE + SPAN - 1 - (b - BASE)];
    end

    assign mid = flip_en ? flipped : d_in;

    for (genvar n = 0; n < W; n++) begin : g_rev
        assign reversed[n] = mid[W-1-n];
    end

    assign d_out = rev_en ? reversed : mid;
endmodule

// File: rtl/txs_slip.sv
module txs_slip #(
    parameter int W   = 10,
    parameter int SLW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [W-1:0]   cur,
    input  logic [SLW-1:0] slip,
    output logic [W-1:0]   window
);
    logic [W-1:0]   hist_q;
    logic [2*W-1:0] joined;
    logic [2*W-1:0] shifted;
    int             eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (load) begin
            hist_q <= cur;
        end
    end

    always_comb begin
        eff     = (int'(slip) > W - 1) ? W - 1 : int'(slip);
        joined  = {cur, hist_q};
        shifted = joined >> (W - eff);
        window  = shifted[W-1:0];
    end
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load,
    output logic active
);
    localparam int H  = W / 2;
    localparam int PW = $clog2(H);

    txs_state_e    state_q, state_d;
    logic [PW-1:0] phase_q;
    logic          last;

    assign last = (phase_q == PW'(H - 1));

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_SHIFT;
                    load    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    if (in_valid) begin
                        load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                phase_q <= '0;
            end else if (state_q == ST_SHIFT) begin
                phase_q <= phase_q + PW'(1);
            end
        end
    end

    always_comb begin
        active = (state_q == ST_SHIFT);
    end

    // R1: a word is never taken on two adjacent cycles
    p_cadence_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    // R3: an accepted word is shifted out from the next cycle
    p_load_active_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> active);

    // R10: a missing strobe at the boundary ends the burst
    p_gap_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (active && last && !in_valid) |=> !active);
endmodule

// File: rtl/tx_slip_serializer.sv
module tx_slip_serializer #(
    parameter int  W   = 10,
    localparam int SLW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_word,
    input  logic           flip_en,
    input  logic           rev_en,
    input  logic [SLW-1:0] slip_amt,
    output logic [1:0]     out_pair,
    output logic           out_valid
);
    logic         load;
    logic         active;
    logic [W-1:0] ord_word;
    logic [W-1:0] slip_word;
    logic [W-1:0] shreg_q;

    txs_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .load     (load),
        .active   (active)
    );

    txs_bitorder #(.W(W)) u_order (
        .d_in    (in_word),
        .flip_en (flip_en),
        .rev_en  (rev_en),
        .d_out   (ord_word)
    );

    txs_slip #(.W(W), .SLW(SLW)) u_slip (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cur    (ord_word),
        .slip   (slip_amt),
        .window (slip_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= slip_word;
        end else if (active) begin
            shreg_q <= shreg_q >> 2;
        end
    end

    always_comb begin
        out_valid = active;
        out_pair  = active ? shreg_q[1:0] : 2'b00;
    end

    // R4: flip and reversal only permute bits
    p_perm_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(ord_word) == $countones(in_word));

    // R7: with zero slip the first pair is the low pair of the ordered word
    p_slip0_r7: assert property (@(posedge clk) disable iff (rst)
        (load && slip_amt == '0) |=> (out_pair == $past(ord_word[1:0])));
endmodule

// File: tb/tx_slip_serializer_tb.sv
`timescale 1ns/1ps

module txs_lane_check #(
    parameter int W = 10
) (
    input logic clk
);
    localparam int H   = W / 2;
    localparam int N   = 6;
    localparam int SLW = $clog2(W);

    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_word = '0;
    logic           flip = 1'b0;
    logic           rev = 1'b0;
    logic [SLW-1:0] slip = '0;
    logic [1:0]     pair;
    logic           ov;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    bit           got [N*W];
    logic [W-1:0] words [N];
    logic [W-1:0] proc [N];
    int           sk [N];

    tx_slip_serializer #(.W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .flip_en   (flip),
        .rev_en    (rev),
        .slip_amt  (slip),
        .out_pair  (pair),
        .out_valid (ov)
    );

    function automatic logic [W-1:0] ref_order(logic [W-1:0] d, bit f, bit r);
        logic [W-1:0] a, z;
        for (int b = 0; b < W; b++) begin
            int g, sz;
            g  = (b / 8) * 8;
            sz = (W - g < 8) ? W - g : 8;
            a[b] = f ? d[g + sz - 1 - (b - g)] : d[b];
        end
        for (int n = 0; n < W; n++) z[n] = r ? a[W-1-n] : a[n];
        return z;
    endfunction

    function automatic bit ref_bit(int pos);
        int k, src;
        k   = pos / W;
        src = pos - sk[k];
        if (src < 0) return 1'b0;
        return proc[src / W][src % W];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s W=%0d actual=%0h expected=%0h", tag, W, act, exp);
        end
    endtask

    task automatic run(bit f, bit r, int s0, int s1);
        flip = f;
        rev  = r;
        for (int k = 0; k < N; k++) begin
            int s;
            s = (k < 3) ? s0 : s1;
            sk[k] = (s > W - 1) ? W - 1 : s;
            words[k] = (k == 0) ? W'(10'h2BC) : W'(k * 173 + f * 29 + r * 71 + s0 * 13 + 7);
            proc[k] = ref_order(words[k], f, r);
        end
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; slip = SLW'(s0);
        @(posedge clk); #2;
        check(!ov && pair == 2'b00, "R11 reset", {ov, pair}, 0);
        for (int c = 0; c <= N * H; c++) begin
            @(negedge clk);
            rst = 1'b0;
            // R9: a stray strobe sits two cycles into every word
            in_valid = ((c % H == 0) && c < N * H) || (c % H == 2);
            in_word  = (c % H == 0 && c < N * H) ? words[c / H] : '1;
            slip     = (c < 2 * H + 2) ? SLW'(s0) : SLW'(s1);
            @(posedge clk); #2;
            if (c < N * H) begin
                got[2*c]   = pair[0];
                got[2*c+1] = pair[1];
                check(ov == 1'b1, "R1 R3 valid", ov, 1);
            end else begin
                check(!ov && pair == 2'b00, "R10 gap", {ov, pair}, 0);
            end
        end
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] a, e;
            string tag;
            for (int j = 0; j < W; j++) begin
                a[j] = got[k*W + j];
                e[j] = ref_bit(k*W + j);
            end
            if (k >= 3 && s0 != s1) tag = "R8 slip change";
            else if (sk[k] > 0)     tag = "R7 slip";
            else if (f && r)        tag = "R6 flip+rev";
            else if (r)             tag = "R5 reverse";
            else if (f)             tag = "R4 flip";
            else                    tag = "R2 R9 order";
            check(a == e, tag, int'(a), int'(e));
            if (W == 8 && k == 0 && f && !r && s0 == 0)
                check(a == W'(8'h3D), "R4 BC->3D", int'(a), 'h3D);
        end
    endtask

    initial begin
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < W; s++)
                    run(f[0], r[0], s, s);
        run(1'b0, 1'b0, 1, W - 2);
        run(1'b1, 1'b1, W - 1, 0);
        run(1'b1, 1'b0, 2, (1 << SLW) - 1);
        done = 1'b1;
    end
endmodule

module tx_slip_serializer_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    bit wd_hit = 1'b0;

    txs_lane_check #(.W(8))  u_lane8  (.clk(clk));
    txs_lane_check #(.W(10)) u_lane10 (.clk(clk));

    initial begin
        int total_chk, total_err;
        fork
            begin
                wait (u_lane8.done && u_lane10.done);
            end
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        total_chk = u_lane8.n_chk + u_lane10.n_chk;
        total_err = u_lane8.n_err + u_lane10.n_err;
        if (wd_hit) begin
            total_chk++;
            total_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", total_chk, total_err);
        $finish;
    end
endmodule